// File: doc/BRIEF.md
# START-Tolerant Two-Wire Slave Bit Receiver

This block is the receive side of a two-wire serial slave. It recovers the address byte that follows a START condition, checks it against its own address, and then collects the write data bytes that follow, acknowledging each one by pulling the data line low through an open-drain enable. Each received byte that belongs to this slave is presented on a byte output together with a one-cycle valid strobe and a flag that marks the address byte.

Some masters release the clock line after START and pull it low again for a period much shorter than the bus timing rules allow. A receiver that waits to observe clock LOW after START can miss that first bit. This block does not wait for it. After START it lets a parameterised number of system-clock cycles elapse without looking at the clock line. It then takes the first bit as soon as it sees the clock line high, whether or not a LOW phase was seen. The delay is the tuning knob. If it is too short, the clock-high level that is still present from the START is taken as a bit. If it is too long, the whole first clock is missed. Later bits are taken on rising clock edges. Every change of the acknowledge drive waits for a hold window after the clock falls.

Top module: `i2c_start_tolerant_rx`

## Requirements
- R1: After reset the block drives `sda_oe` low and `rx_valid` low.
- R2: START (data falling while clock is high) restarts the address phase. After `BLIND_CYCLES` cycles the first bit is taken while the clock line is high, without a clock LOW phase having been observed. A master whose first LOW phase is 600 ns is therefore received correctly.
- R3: If the blind delay ends while the clock is still high from the START, the low data level of the START is taken as an extra leading bit. With the own address, the shifted byte is not matched and produces no `rx_valid`.
- R4: If the blind delay outlasts the first clock pulse, that clock is missed and the second clock is taken as the first. With the own address, the shifted byte is not matched and produces no `rx_valid`.
- R5: Bits are shifted in MSB first on clock rising edges. A completed byte for this slave appears on `rx_data` with a one-cycle `rx_valid` pulse. `rx_is_addr` is 1 for the address byte and 0 for data bytes.
- R6: When bits 7..1 of the address byte equal `OWN_ADDR` and bit 0 is 0 (write), the block pulls the data line low during the ninth clock. It does the same for every following data byte.
- R7: When bits 7..1 of the address byte differ from `OWN_ADDR`, there is no acknowledge and no `rx_valid`, and later bytes are ignored until the next START.
- R8: STOP (data rising while clock is high) aborts any partial byte without an `rx_valid` and leaves `sda_oe` low.
- R9: A repeated START in the middle of a data byte discards that byte and begins a new address phase.
- R10: `sda_oe` changes only after at least `HOLD_CYCLES` system clocks have passed since the last clock falling edge.
- R11: A matching address byte with bit 0 equal to 1 (read) is acknowledged and reported. The block then returns to idle, and later bytes get neither acknowledge nor `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| rx_data | output | DATA_W | Last received byte, MSB first on the wire |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| rx_is_addr | output | 1 | The strobed byte was the address byte |

## Verification
Several properties are checked on every cycle: the acknowledge enable never changes inside the hold window after a clock fall, a START always leads straight into the blind wait, a STOP always leaves the data line released, and the valid strobe never lasts two cycles. Other behaviour depends on real bus timing, so only the bench scenarios can show it. This covers correct capture after a 600 ns first LOW, the added bit when the blind delay is too short and the lost bit when it is too long, and the acknowledge values seen on the wire for matching, foreign and read addresses. It also covers aborts by STOP and by repeated START in the middle of a byte.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_BLIND,
      S_FIRST,
      S_SHIFT,
      S_ACK_WAIT,
      S_ACK_SET,
      S_ACK_HIGH,
      S_ACK_END,
      S_ACK_REL
   } srx_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic scl;
      logic sda;
   } srx_bus_ev_t;

endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_srx_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '1;
            else        chain[i] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_srx_events.sv
module i2c_srx_events
   import i2c_srx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_s,
   input  logic        sda_s,
   output srx_bus_ev_t ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      ev.scl   = scl_s;
      ev.sda   = sda_s;
      ev.rise  = scl_s & ~scl_q;
      ev.fall  = ~scl_s & scl_q;
      ev.start = scl_s & scl_q & sda_q & ~sda_s;
      ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
   end
endmodule

// File: rtl/i2c_srx_holdtmr.sv
module i2c_srx_holdtmr #(
   parameter int HOLD_CYCLES = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_fall,
   output logic hold_ok
);
   localparam int HW = $clog2(HOLD_CYCLES + 1);
   localparam logic [HW-1:0] HMAX = HW'(HOLD_CYCLES);

   logic [HW-1:0] cnt;

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("i2c_srx_holdtmr: HOLD_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= HMAX;
      else if (scl_fall)    cnt <= '0;
      else if (cnt != HMAX) cnt <= cnt + 1'b1;
   end

   assign hold_ok = (cnt == HMAX);
endmodule

// File: rtl/i2c_srx_core.sv
module i2c_srx_core
   import i2c_srx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int OWN_ADDR     = 45,
   parameter int BLIND_CYCLES = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  srx_bus_ev_t       ev,
   input  logic              hold_ok,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_is_addr
);
   localparam int ADDR_W = DATA_W - 1;
   localparam int CW     = $clog2(DATA_W + 1);
   localparam int BW     = $clog2(BLIND_CYCLES + 1);
   localparam logic [CW-1:0]     LAST_BIT = CW'(DATA_W - 1);
   localparam logic [BW-1:0]     BLIND_LAST = BW'(BLIND_CYCLES - 1);
   localparam logic [ADDR_W-1:0] OWN = ADDR_W'(OWN_ADDR);

   if (DATA_W < 2) begin : g_bad_width
      $error("i2c_srx_core: DATA_W must be at least 2");
   end
   if (BLIND_CYCLES < 1) begin : g_bad_blind
      $error("i2c_srx_core: BLIND_CYCLES must be at least 1");
   end
   if (OWN_ADDR < 0 || OWN_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("i2c_srx_core: OWN_ADDR does not fit the address field");
   end

   srx_state_e        state;
   logic [BW-1:0]     blind_cnt;
   logic [CW-1:0]     bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              addr_ph;
   logic              rd_mode;
   logic [DATA_W-1:0] nxt_byte;
   logic              hit;

   assign nxt_byte = {shreg[DATA_W-2:0], ev.sda};
   assign hit      = (nxt_byte[DATA_W-1:1] == OWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         blind_cnt  <= '0;
         bit_cnt    <= '0;
         shreg      <= '0;
         addr_ph    <= 1'b0;
         rd_mode    <= 1'b0;
         sda_oe     <= 1'b0;
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         rx_is_addr <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (ev.start) begin
            state     <= S_BLIND;
            blind_cnt <= '0;
            bit_cnt   <= '0;
            addr_ph   <= 1'b1;
            rd_mode   <= 1'b0;
            sda_oe    <= 1'b0;
         end else if (ev.stop) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else begin
            case (state)
               S_IDLE: ;
               S_BLIND: begin
                  if (blind_cnt == BLIND_LAST) state <= S_FIRST;
                  else                         blind_cnt <= blind_cnt + 1'b1;
               end
               S_FIRST: begin
                  if (ev.scl) begin
                     shreg   <= nxt_byte;
                     bit_cnt <= CW'(1);
                     state   <= S_SHIFT;
                  end
               end
               S_SHIFT: begin
                  if (ev.rise) begin
                     shreg <= nxt_byte;
                     if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        if (addr_ph) begin
                           if (hit) begin
                              rx_valid   <= 1'b1;
                              rx_data    <= nxt_byte;
                              rx_is_addr <= 1'b1;
                              addr_ph    <= 1'b0;
                              rd_mode    <= nxt_byte[0];
                              state      <= S_ACK_WAIT;
                           end else begin
                              state <= S_IDLE;
                           end
                        end else begin
                           rx_valid   <= 1'b1;
                           rx_data    <= nxt_byte;
                           rx_is_addr <= 1'b0;
                           state      <= S_ACK_WAIT;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               S_ACK_WAIT: if (ev.fall) state <= S_ACK_SET;
               S_ACK_SET: begin
                  if (hold_ok) begin
                     sda_oe <= 1'b1;
                     state  <= S_ACK_HIGH;
                  end
               end
               S_ACK_HIGH: if (ev.rise) state <= S_ACK_END;
               S_ACK_END:  if (ev.fall) state <= S_ACK_REL;
               S_ACK_REL: begin
                  if (hold_ok) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= rd_mode ? S_IDLE : S_SHIFT;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   // R2: a START always leads into the blind wait
   p_start_blind_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev.start |=> (state == S_BLIND));

   // R8: a STOP leaves the data line released
   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> !sda_oe);

   // R5: byte strobe is a single-cycle pulse
   p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R5: bit counter never runs past one byte
   p_bitcnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CW'(DATA_W));
endmodule

// File: rtl/i2c_start_tolerant_rx.sv
module i2c_start_tolerant_rx
   import i2c_srx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int OWN_ADDR     = 45,
   parameter int SYNC_STAGES  = 2,
   parameter int BLIND_CYCLES = 40,
   parameter int HOLD_CYCLES  = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_is_addr
);
   logic [1:0]  pins_s;
   srx_bus_ev_t ev;
   logic        hold_ok;

   i2c_srx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (pins_s)
   );

   i2c_srx_events u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (pins_s[1]),
      .sda_s (pins_s[0]),
      .ev    (ev)
   );

   i2c_srx_holdtmr #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_fall (ev.fall),
      .hold_ok  (hold_ok)
   );

   i2c_srx_core #(
      .DATA_W       (DATA_W),
      .OWN_ADDR     (OWN_ADDR),
      .BLIND_CYCLES (BLIND_CYCLES)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (ev),
      .hold_ok    (hold_ok),
      .sda_oe     (sda_oe),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_is_addr (rx_is_addr)
   );

   // R10: acknowledge drive changes only outside the post-fall hold window
   p_oe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> $past(hold_ok));
endmodule

// File: tb/i2c_start_tolerant_rx_test.sv
module i2c_start_tolerant_rx_test;
   localparam int HOLD = 30;
   localparam int OWN  = 45;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   always #5 clk = ~clk;

   logic       oe_main, oe_s, oe_l;
   logic [7:0] rxd, rxd_s, rxd_l;
   logic       rxv, rxa, rxv_s, rxa_s, rxv_l, rxa_l;
   wire        sda_ln = sda_m & ~oe_main;

   i2c_start_tolerant_rx #(.OWN_ADDR(OWN), .BLIND_CYCLES(40), .HOLD_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln),
      .sda_oe(oe_main), .rx_data(rxd), .rx_valid(rxv), .rx_is_addr(rxa));

   i2c_start_tolerant_rx #(.OWN_ADDR(OWN), .BLIND_CYCLES(2), .HOLD_CYCLES(HOLD)) u_short (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln),
      .sda_oe(oe_s), .rx_data(rxd_s), .rx_valid(rxv_s), .rx_is_addr(rxa_s));

   i2c_start_tolerant_rx #(.OWN_ADDR(OWN), .BLIND_CYCLES(130), .HOLD_CYCLES(HOLD)) u_long (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln),
      .sda_oe(oe_l), .rx_data(rxd_l), .rx_valid(rxv_l), .rx_is_addr(rxa_l));

   int n_chk = 0, n_bad = 0;
   int cyc = 0, fall_cyc = 0;
   int vcnt = 0, vs = 0, vl = 0, oe_chg = 0, min_gap = 1000000;
   logic [7:0] last_d = 8'h00;
   logic last_a = 1'b0;
   logic oe_prev = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rxv) begin vcnt++; last_d = rxd; last_a = rxa; end
      if (rxv_s) vs++;
      if (rxv_l) vl++;
      if (oe_main !== oe_prev) begin
         oe_chg++;
         if (cyc - fall_cyc < min_gap) min_gap = cyc - fall_cyc;
      end
      oe_prev = oe_main;
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic scl_lo;
      scl_m = 1'b0;
      fall_cyc = cyc;
   endtask

   task automatic m_start;
      sda_m = 1'b0;
      wc(10);
   endtask

   task automatic m_bit(bit b);
      scl_lo(); wc(30); sda_m = b; wc(30); scl_m = 1'b1; wc(50);
   endtask

   task automatic m_byte(logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) m_bit(b[i]);
      scl_lo(); wc(30); sda_m = 1'b1; wc(30); scl_m = 1'b1; wc(25);
      acked = !sda_ln;
      wc(25);
   endtask

   task automatic m_stop;
      scl_lo(); wc(30); sda_m = 1'b0; wc(30); scl_m = 1'b1; wc(30); sda_m = 1'b1; wc(60);
   endtask

   task automatic m_rstart;
      scl_lo(); wc(30); sda_m = 1'b1; wc(30); scl_m = 1'b1; wc(30); m_start();
   endtask

   task automatic t_reset;
      wc(3);
      chk("R1 sda_oe in reset", int'(oe_main), 0);
      chk("R1 rx_valid in reset", int'(rxv), 0);
      rst_n = 1'b1;
      wc(20);
      chk("R1 sda_oe after reset", int'(oe_main), 0);
   endtask

   task automatic t_write;
      int v0 = vcnt;
      bit a;
      m_start();
      m_byte(8'h5A, a);
      chk("R6 ack own write address", int'(a), 1);
      chk("R2 address byte received after short first low", vcnt, v0 + 1);
      chk("R5 address byte value", int'(last_d), 'h5A);
      chk("R5 address flag", int'(last_a), 1);
      m_byte(8'hC3, a);
      chk("R6 ack data byte", int'(a), 1);
      chk("R5 data byte strobe", vcnt, v0 + 2);
      chk("R5 data byte value", int'(last_d), 'hC3);
      chk("R5 data flag", int'(last_a), 0);
      m_stop();
      chk("R8 released after stop", int'(oe_main), 0);
      chk("R3 short blind adds a bit, no match", vs, 0);
      chk("R4 long blind loses a bit, no match", vl, 0);
   endtask

   task automatic t_mismatch;
      int v0 = vcnt;
      bit a;
      wc(50);
      m_start();
      m_byte(8'h44, a);
      chk("R7 no ack foreign address", int'(a), 0);
      chk("R7 no strobe foreign address", vcnt, v0);
      m_byte(8'h5A, a);
      chk("R7 later byte not acked", int'(a), 0);
      chk("R7 later byte not strobed", vcnt, v0);
      m_stop();
   endtask

   task automatic t_stop_abort;
      int v0 = vcnt;
      bit a;
      wc(50);
      m_start();
      m_byte(8'h5A, a);
      m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
      m_stop();
      chk("R8 partial byte dropped by stop", vcnt, v0 + 1);
      chk("R8 sda_oe low after stop", int'(oe_main), 0);
   endtask

   task automatic t_rstart;
      int v0 = vcnt;
      bit a;
      wc(50);
      m_start();
      m_byte(8'h5A, a);
      m_bit(1'b0); m_bit(1'b1); m_bit(1'b1); m_bit(1'b0);
      m_rstart();
      m_byte(8'h5A, a);
      chk("R9 ack after repeated start", int'(a), 1);
      chk("R9 partial byte discarded", vcnt, v0 + 2);
      chk("R9 new address phase flag", int'(last_a), 1);
      m_byte(8'h11, a);
      chk("R9 data after repeated start", int'(last_d), 'h11);
      chk("R9 data strobe count", vcnt, v0 + 3);
      m_stop();
   endtask

   task automatic t_read;
      int v0 = vcnt;
      bit a;
      wc(50);
      m_start();
      m_byte(8'h5B, a);
      chk("R11 read address acked", int'(a), 1);
      chk("R11 read address strobed", vcnt, v0 + 1);
      m_byte(8'hFF, a);
      chk("R11 no ack after read address", int'(a), 0);
      chk("R11 no strobe after read address", vcnt, v0 + 1);
      m_stop();
   endtask

   task automatic t_hold;
      chk("R10 acknowledge drive toggled", int'(oe_chg > 0), 1);
      chk("R10 min gap after clock fall", int'(min_gap >= HOLD), 1);
      chk("R3 short blind never strobes", vs, 0);
      chk("R4 long blind never strobes", vl, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write();
      t_mismatch();
      t_stop_abort();
      t_rstart();
      t_read();
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule